// File: doc/BRIEF.md
# Complementary Gate Pulse Generator with Dead Time

This block turns a 16-bit duty command into gate drive for two half-bridge legs of a power converter. A free-running carrier counter divides the fast clock into switching periods of a fixed number of counts (2000 counts by default, which gives a 50 kHz switching rate from a 100 MHz clock). A comparison between the carrier and the latched duty command sets the raw switch state. Each leg has a high-side and a low-side gate, and the two are driven in complement.

Every gate turns on only after its raw drive has been asserted without a break for a programmable number of clock cycles. Every gate turns off on the next clock edge. This delay on the rising edge of each gate gives a dead interval at every transition, so the two switches of a leg are never on together. A mode input picks which switch of the leg carries the duty: the low side in boost operation, the high side in buck operation. The second leg runs in phase opposition to the first. When the enable input is low, every gate is held off. The duty command is taken in only at the period boundary, so a period never sees a change partway through.

Top module: `pwm_gate_gen`

## Requirements
- R1: The carrier counts 0 up to PERIOD-1 and then wraps to 0, so the gate pattern repeats every PERIOD clock cycles.
- R2: `duty_cmd` is latched only on the edge where the carrier wraps to 0. A change partway through a period first takes effect in the next period.
- R3: A latched duty above PERIOD behaves as PERIOD, and then the modulated switch's raw drive is on for the whole period. A duty of 0 keeps that raw drive off for the whole period.
- R4: With `boost_mode`=0 (buck), the raw drive of leg 0's high side is on while carrier < duty. The raw drive of its low side is the complement.
- R5: With `boost_mode`=1 (boost), the raw drive of leg 0's low side is on while carrier < duty. The raw drive of its high side is the complement.
- R6: A gate output goes high on the (dead_cnt+1)-th clock edge of an unbroken run of its raw drive (and of enable). It goes low on the first edge at which its raw drive is off. In steady state the modulated gate is therefore on max(duty-dead_cnt,0) cycles per period.
- R7: Leg 1 is phase-opposed to leg 0: the raw drive of leg 1's high side equals that of leg 0's low side, and the other way round.
- R8: With `en`=0 every gate output is 0 from the next clock edge onward. The carrier keeps running.
- R9: On no clock cycle are the high and low gates of the same leg both 1.
- R10: Synchronous active-high `rst` clears the carrier, the latched duty and all gate outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast pulse-generator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Gate enable; 0 forces all gates off |
| boost_mode | input | 1 | 1 = low side modulated, 0 = high side modulated |
| duty_cmd | input | CNT_W | Duty command in carrier counts |
| dead_cnt | input | DT_W | Turn-on delay in clock cycles |
| gate_hi | output | LEGS | High-side gate per leg |
| gate_lo | output | LEGS | Low-side gate per leg |

## Verification
The bench builds the block with PERIOD=20, an 8-bit carrier and an 8-bit dead-time counter. This keeps a full period short enough that many periods fit into one run. It brings within reach the carrier wrap, a duty command above the period, a duty equal to the period, and dead times that are zero, small, or larger than the duty. With periods this short, per-period on-counts and the exact turn-on delay after enable can be compared with values worked out by hand from the requirements.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_PERIOD = 2000;
    localparam int DEF_DT_W   = 16;
    localparam int DEF_LEGS   = 2;

    typedef enum logic {
        MODE_BUCK  = 1'b0,
        MODE_BOOST = 1'b1
    } conv_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drive_t;

    // Map the carrier comparison onto the two switches of one leg.
    function automatic leg_drive_t leg_raw(input logic on_phase, input conv_mode_e mode);
        leg_drive_t d;
        if (mode == MODE_BOOST) begin
            d.lo = on_phase;
            d.hi = ~on_phase;
        end else begin
            d.hi = on_phase;
            d.lo = ~on_phase;
        end
        return d;
    endfunction

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
    parameter int CNT_W  = pwm_gate_pkg::DEF_CNT_W,
    parameter int PERIOD = pwm_gate_pkg::DEF_PERIOD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_cmd,
    output logic             on_phase
);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(PERIOD);

    logic [CNT_W-1:0] carrier_q;
    logic [CNT_W-1:0] duty_q;
    logic             wrap;

    assign wrap = (carrier_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier_q <= '0;
            duty_q    <= '0;
        end else begin
            carrier_q <= wrap ? '0 : carrier_q + 1'b1;
            if (wrap)
                duty_q <= (duty_cmd > FULL) ? FULL : duty_cmd;
        end
    end

    assign on_phase = (carrier_q < duty_q);

    // R1
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        carrier_q <= LAST);

    // R1
    carrier_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier_q == LAST) |=> (carrier_q == '0));

    // R2
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier_q != '0) |-> $stable(duty_q));

    // R3
    duty_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        duty_q <= FULL);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int DT_W = pwm_gate_pkg::DEF_DT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            raw,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            gate
);
    logic [DT_W-1:0] run_q;
    logic            gate_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !raw) begin
            run_q  <= '0;
            gate_q <= 1'b0;
        end else if (run_q >= dead_cnt) begin
            gate_q <= 1'b1;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign gate = gate_q;

    // R6
    turn_on_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> $past(raw && en));

    // R6
    turn_off_fast_chk: assert property (@(posedge clk) disable iff (rst)
        !raw |=> !gate_q);

    // R8
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate_q);

endmodule

// File: rtl/pwm_gate_gen.sv
module pwm_gate_gen #(
    parameter int CNT_W  = pwm_gate_pkg::DEF_CNT_W,
    parameter int PERIOD = pwm_gate_pkg::DEF_PERIOD,
    parameter int DT_W   = pwm_gate_pkg::DEF_DT_W,
    parameter int LEGS   = pwm_gate_pkg::DEF_LEGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             boost_mode,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]  dead_cnt,
    output logic [LEGS-1:0]  gate_hi,
    output logic [LEGS-1:0]  gate_lo
);
    import pwm_gate_pkg::*;

    logic       on_phase;
    conv_mode_e mode;

    assign mode = conv_mode_e'(boost_mode);

    pwm_carrier #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .duty_cmd (duty_cmd),
        .on_phase (on_phase)
    );

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        leg_drive_t raw;
        // Odd legs run in phase opposition to even legs.
        assign raw = leg_raw((i % 2 == 0) ? on_phase : ~on_phase, mode);

        pwm_deadband #(.DT_W(DT_W)) u_hi (
            .clk (clk), .rst (rst), .en (en), .raw (raw.hi),
            .dead_cnt (dead_cnt), .gate (gate_hi[i])
        );
        pwm_deadband #(.DT_W(DT_W)) u_lo (
            .clk (clk), .rst (rst), .en (en), .raw (raw.lo),
            .dead_cnt (dead_cnt), .gate (gate_lo[i])
        );

        // R9
        leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[i] && gate_lo[i]));
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/sim_pwm_gate_gen.sv
module sim_pwm_gate_gen;
    localparam int P    = 20;
    localparam int CW   = 8;
    localparam int DW   = 8;
    localparam int LEGS = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en = 1'b0;
    logic            boost_mode = 1'b0;
    logic [CW-1:0]   duty_cmd = '0;
    logic [DW-1:0]   dead_cnt = '0;
    logic [LEGS-1:0] gate_hi;
    logic [LEGS-1:0] gate_lo;

    int n_cmp = 0;
    int n_bad = 0;
    int excl_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwm_gate_gen #(.CNT_W(CW), .PERIOD(P), .DT_W(DW), .LEGS(LEGS)) u0 (
        .clk (clk), .rst (rst), .en (en), .boost_mode (boost_mode),
        .duty_cmd (duty_cmd), .dead_cnt (dead_cnt),
        .gate_hi (gate_hi), .gate_lo (gate_lo)
    );

    // R9 monitor: counts cycles with both gates of a leg on.
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < LEGS; i++)
                if (gate_hi[i] && gate_lo[i]) excl_bad++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_mod(input int d, input int n);
        if (d >= P) return P;
        return (d > n) ? d - n : 0;
    endfunction

    function automatic int exp_comp(input int d, input int n);
        if (d >= P) return 0;
        if (d == 0) return P;
        return (P - d > n) ? P - d - n : 0;
    endfunction

    task automatic measure(output int ha, output int la, output int hb, output int lb);
        ha = 0; la = 0; hb = 0; lb = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            ha += gate_hi[0]; la += gate_lo[0];
            hb += gate_hi[1]; lb += gate_lo[1];
        end
    endtask

    task automatic setup(input bit boost, input int d, input int n);
        @(negedge clk);
        boost_mode = boost; duty_cmd = CW'(d); dead_cnt = DW'(n); en = 1'b1;
        repeat (3 * P) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 gates after reset", int'({gate_hi, gate_lo}), 0);
    endtask

    task automatic t_steady(input string req, input bit boost, input int d, input int n);
        int ha, la, hb, lb;
        int emod, ecomp;
        setup(boost, d, n);
        measure(ha, la, hb, lb);
        emod = exp_mod(d, n); ecomp = exp_comp(d, n);
        if (!boost) begin
            check({req, " leg0 hi"}, ha, emod);
            check({req, " leg0 lo"}, la, ecomp);
            check({req, " R7 leg1 hi"}, hb, ecomp);
            check({req, " R7 leg1 lo"}, lb, emod);
        end else begin
            check({req, " leg0 lo"}, la, emod);
            check({req, " leg0 hi"}, ha, ecomp);
            check({req, " R7 leg1 lo"}, lb, ecomp);
            check({req, " R7 leg1 hi"}, hb, emod);
        end
    endtask

    task automatic t_period();
        int gap;
        setup(1'b0, 8, 2);
        while (!(gate_hi[0] == 1'b0)) @(negedge clk);
        while (gate_hi[0] == 1'b0) @(negedge clk);
        gap = 0;
        while (gate_hi[0] == 1'b1) begin @(negedge clk); gap++; end
        while (gate_hi[0] == 1'b0) begin @(negedge clk); gap++; end
        check("R1 rise-to-rise distance", gap, P);
    endtask

    task automatic t_mid_update();
        int cnt;
        setup(1'b0, 10, 2);
        while (gate_hi[0] == 1'b1) @(negedge clk);
        while (gate_hi[0] == 1'b0) @(negedge clk);
        duty_cmd = CW'(16);
        cnt = 0;
        while (gate_hi[0] == 1'b1) begin cnt++; @(negedge clk); end
        check("R2 period with mid update keeps old duty", cnt, 8);
        while (gate_hi[0] == 1'b0) @(negedge clk);
        cnt = 0;
        while (gate_hi[0] == 1'b1) begin cnt++; @(negedge clk); end
        check("R2 following period uses new duty", cnt, 14);
    endtask

    task automatic t_enable();
        int on_sum, first;
        setup(1'b0, 8, 2);
        en = 1'b0;
        on_sum = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            on_sum += $countones({gate_hi, gate_lo});
        end
        check("R8 gates with enable low", on_sum, 0);
        duty_cmd = CW'(P); dead_cnt = DW'(5);
        repeat (2 * P) @(negedge clk);
        en = 1'b1;
        first = 0;
        for (int k = 1; k <= 12 && first == 0; k++) begin
            @(negedge clk);
            if (gate_hi[0]) first = k;
        end
        check("R6 turn-on edge count after enable", first, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_steady("R4 buck d8 n2", 1'b0, 8, 2);
        t_steady("R5 boost d8 n2", 1'b1, 8, 2);
        t_steady("R5 boost d13 n3", 1'b1, 13, 3);
        t_steady("R6 no dead time", 1'b0, 7, 0);
        t_steady("R6 dead time above duty", 1'b0, 3, 5);
        t_steady("R3 zero duty", 1'b0, 0, 2);
        t_steady("R3 duty above period", 1'b0, 50, 2);
        t_steady("R3 duty equal period", 1'b1, P, 2);
        t_period();
        t_mid_update();
        t_enable();
        check("R9 cycles with both gates of a leg on", excl_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule